// File: doc/BRIEF.md
# Self-Checking Sequencer Instruction Decoder

This block turns a 4-bit sequencer opcode, a condition bit and a counter-zero bit into the control lines of a microprogram sequencer. It drives nine internal controls: reset, program-counter clear, counter load, counter decrement, counter-to-address enable, stack-to-address enable, external-to-address enable, push and pop. It also drives three mutually exclusive source enables and active-low copies of push and pop.

Alongside the controls it emits a 3-bit check word. The word is the number of zeros across the opcode and the twelve main controls, minus eight. A checker recovers the output code by subtracting the opcode's own check bits, modulo 8, and compares the result with a code it builds from the controls themselves. The same checker tests several complementary pairs:

- the condition bit against its separately supplied complement,
- the zero bit against the complementary zero from a second counter copy,
- push and pop against their inverted copies,
- the two-rail result of an external counter load checker.

All of these pairs are reduced by a tree of two-rail cells. The resulting pair is registered, so it reports one cycle after the controls are decoded. A complementary pair (01 or 10) means no error. A pair of 00 or 11 flags an error.

Top module: `seq_decode_chk`

## Requirements
- R1: Opcodes with fixed behaviour. Opcode 0 raises reset, pc-clear and the pipeline enable. Opcode 2 raises external-enable and the map enable. Opcode 12 raises counter load and the pipeline enable. Opcode 14 raises only the pipeline enable.
- R2: Condition-driven opcodes use the pipeline enable unless stated otherwise. With `cc`=1 they do the following. Opcode 1: external and push. Opcode 3: external. Opcode 4: push, plus load. Opcode 5: push, plus external. Opcode 6: vector enable instead of pipeline, plus external. Opcode 7: external. Opcode 10: stack and pop. Opcode 11: external and pop. Opcode 13: pop. With `cc`=0 the conditional parts drop, with two exceptions: opcodes 5 and 7 raise counter-enable instead, and opcode 13 raises stack instead.
- R3: Counter-driven opcodes use the pipeline enable. Opcode 8: pop if `rz`=1, otherwise stack and decrement. Opcode 9: nothing more if `rz`=1, otherwise external and decrement. Opcode 15: pop if `cc`=1; otherwise stack and decrement when `rz`=0, or external and pop when `rz`=1.
- R4: Exactly one of `en_pl`, `en_map`, `en_vec` is high for every input pattern.
- R5: `ctl_push_n` and `ctl_pop_n` are always the complements of `ctl_push` and `ctl_pop`.
- R6: `chk_word` equals 8 minus the number of ones across `op` and the twelve main controls. It lies in 0 to 6 for every input pattern.
- R7: When every checked input is consistent, `err_rail` is complementary one cycle later. Consistent means `op_zc` equals the zero count of `op`, `cc_n`=~`cc`, `rz_n`=~`rz`, and `ld_rail` is 01 or 10.
- R8: Any `op_zc` value other than the zero count of `op` drives `err_rail` to 00 or 11 one cycle later.
- R9: `cc_n` equal to `cc` drives `err_rail` to 00 or 11 one cycle later.
- R10: `rz_n` equal to `rz` drives `err_rail` to 00 or 11 one cycle later.
- R11: `ld_rail` of 00 or 11 drives `err_rail` to 00 or 11 one cycle later.
- R12: While `rst_n` is low, `err_rail` is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Sequencer opcode |
| op_zc | input | 3 | Supplied zero count of `op` |
| cc | input | 1 | Condition bit (1 = pass) |
| cc_n | input | 1 | Supplied complement of `cc` |
| rz | input | 1 | Counter-is-zero bit |
| rz_n | input | 1 | Complementary zero bit from second counter copy |
| ld_rail | input | 2 | Two-rail result of counter load checker |
| ctl_reset | output | 1 | Reset control |
| ctl_pcclr | output | 1 | Program-counter clear |
| ctl_ld | output | 1 | Counter load |
| ctl_dec | output | 1 | Counter decrement |
| ctl_regoe | output | 1 | Counter drives the address |
| ctl_stkoe | output | 1 | Stack top drives the address |
| ctl_extoe | output | 1 | External input drives the address |
| ctl_push | output | 1 | Stack push |
| ctl_pop | output | 1 | Stack pop |
| ctl_push_n | output | 1 | Inverted push |
| ctl_pop_n | output | 1 | Inverted pop |
| en_pl | output | 1 | Pipeline source enable |
| en_map | output | 1 | Map source enable |
| en_vec | output | 1 | Vector source enable |
| chk_word | output | 3 | Offset zero-count check word |
| err_rail | output | 2 | Registered two-rail error pair |

## Verification
Only the leaves fed from ports can be pushed into an error from outside. These are the opcode check bits, the two complement references and the load pair. The leaves fed by the decoder's own outputs can only be reached by a fault inside the block. The bench therefore sweeps every opcode with every wrong `op_zc` value, so every nonzero difference reaches the subtract-and-compare path. It also breaks each complementary reference and the load pair under several opcodes. Each of these errors must show on `err_rail` in the following cycle, while the controls stay correct.

// File: rtl/seq_decode_chk.sv
module seq_decode_chk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  input  logic [2:0] op_zc,
  input  logic       cc,
  input  logic       cc_n,
  input  logic       rz,
  input  logic       rz_n,
  input  logic [1:0] ld_rail,
  output logic       ctl_reset,
  output logic       ctl_pcclr,
  output logic       ctl_ld,
  output logic       ctl_dec,
  output logic       ctl_regoe,
  output logic       ctl_stkoe,
  output logic       ctl_extoe,
  output logic       ctl_push,
  output logic       ctl_pop,
  output logic       ctl_push_n,
  output logic       ctl_pop_n,
  output logic       en_pl,
  output logic       en_map,
  output logic       en_vec,
  output logic [2:0] chk_word,
  output logic [1:0] err_rail
);
  localparam int NCTL  = 12;
  localparam int NLEAF = 8;

  logic [NCTL-1:0] ctl;

  always_comb begin
    ctl = '0;
    // bit order: reset pcclr ld dec regoe stkoe extoe push pop pl map vec
    unique case (op)
      4'h0: begin ctl[11] = 1'b1; ctl[10] = 1'b1; ctl[2] = 1'b1; end
      4'h1: begin ctl[2] = 1'b1; ctl[5] = cc; ctl[4] = cc; end
      4'h2: begin ctl[1] = 1'b1; ctl[5] = 1'b1; end
      4'h3: begin ctl[2] = 1'b1; ctl[5] = cc; end
      4'h4: begin ctl[2] = 1'b1; ctl[4] = 1'b1; ctl[9] = cc; end
      4'h5: begin ctl[2] = 1'b1; ctl[4] = 1'b1; ctl[5] = cc; ctl[7] = ~cc; end
      4'h6: begin ctl[0] = 1'b1; ctl[5] = cc; end
      4'h7: begin ctl[2] = 1'b1; ctl[5] = cc; ctl[7] = ~cc; end
      4'h8: begin ctl[2] = 1'b1; ctl[3] = rz; ctl[6] = ~rz; ctl[8] = ~rz; end
      4'h9: begin ctl[2] = 1'b1; ctl[5] = ~rz; ctl[8] = ~rz; end
      4'hA: begin ctl[2] = 1'b1; ctl[6] = cc; ctl[3] = cc; end
      4'hB: begin ctl[2] = 1'b1; ctl[5] = cc; ctl[3] = cc; end
      4'hC: begin ctl[2] = 1'b1; ctl[9] = 1'b1; end
      4'hD: begin ctl[2] = 1'b1; ctl[3] = cc; ctl[6] = ~cc; end
      4'hE: begin ctl[2] = 1'b1; end
      4'hF: begin
        ctl[2] = 1'b1;
        ctl[3] = cc | rz;
        ctl[6] = ~cc & ~rz;
        ctl[8] = ~cc & ~rz;
        ctl[5] = ~cc & rz;
      end
      default: ctl = '0;
    endcase
  end

  assign {ctl_reset, ctl_pcclr, ctl_ld, ctl_dec, ctl_regoe, ctl_stkoe,
          ctl_extoe, ctl_push, ctl_pop, en_pl, en_map, en_vec} = ctl;
  assign ctl_push_n = ~ctl[4];
  assign ctl_pop_n  = ~ctl[3];

  logic [4:0] ones_all;
  logic [3:0] ones_ctl;
  always_comb begin
    ones_ctl = '0;
    for (int i = 0; i < NCTL; i++) ones_ctl = ones_ctl + {3'b0, ctl[i]};
    ones_all = {1'b0, ones_ctl};
    for (int i = 0; i < 4; i++) ones_all = ones_all + {4'b0, op[i]};
  end

  logic [4:0] word5;
  assign word5    = 5'd8 - ones_all;
  assign chk_word = word5[2:0];

  logic [2:0] diff, regen;
  logic [3:0] regen4;
  assign diff   = chk_word - op_zc;
  assign regen4 = 4'd4 - ones_ctl;
  assign regen  = regen4[2:0];

  logic [1:0] lv0 [NLEAF];
  logic [1:0] lv1 [NLEAF/2];
  logic [1:0] lv2 [NLEAF/4];
  logic [1:0] root;

  generate
    for (genvar b = 0; b < 3; b++) begin : g_code
      assign lv0[b] = {diff[b], ~regen[b]};
    end
  endgenerate
  assign lv0[3] = {cc, cc_n};
  assign lv0[4] = {rz, rz_n};
  assign lv0[5] = {ctl_push, ctl_push_n};
  assign lv0[6] = {ctl_pop, ctl_pop_n};
  assign lv0[7] = ld_rail;

  generate
    for (genvar k = 0; k < NLEAF/2; k++) begin : g_l1
      assign lv1[k] = {(lv0[2*k][1] & lv0[2*k+1][1]) | (lv0[2*k][0] & lv0[2*k+1][0]),
                       (lv0[2*k][1] & lv0[2*k+1][0]) | (lv0[2*k][0] & lv0[2*k+1][1])};
    end
    for (genvar k = 0; k < NLEAF/4; k++) begin : g_l2
      assign lv2[k] = {(lv1[2*k][1] & lv1[2*k+1][1]) | (lv1[2*k][0] & lv1[2*k+1][0]),
                       (lv1[2*k][1] & lv1[2*k+1][0]) | (lv1[2*k][0] & lv1[2*k+1][1])};
    end
  endgenerate
  assign root = {(lv2[0][1] & lv2[1][1]) | (lv2[0][0] & lv2[1][0]),
                 (lv2[0][1] & lv2[1][0]) | (lv2[0][0] & lv2[1][1])};

  always_ff @(posedge clk) begin
    if (!rst_n) err_rail <= 2'b10;
    else        err_rail <= root;
  end
endmodule

// File: rtl/seq_decode_chk_sva.sv
module seq_decode_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op,
  input logic [2:0] op_zc,
  input logic       cc,
  input logic       cc_n,
  input logic       rz,
  input logic       rz_n,
  input logic [1:0] ld_rail,
  input logic       ctl_push,
  input logic       ctl_pop,
  input logic       ctl_push_n,
  input logic       ctl_pop_n,
  input logic       en_pl,
  input logic       en_map,
  input logic       en_vec,
  input logic [2:0] chk_word,
  input logic [1:0] err_rail
);
  logic inputs_ok;
  assign inputs_ok = (cc != cc_n) && (rz != rz_n) && (ld_rail[1] != ld_rail[0]) &&
                     (op_zc == 3'($countones(~op)));

  // R4
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({en_pl, en_map, en_vec}) == 1);
  // R5
  push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_push != ctl_push_n) && (ctl_pop != ctl_pop_n));
  // R6
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_word <= 3'd6);
  // R7
  clean_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inputs_ok |=> (err_rail[1] != err_rail[0]));
  // R9
  cc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc == cc_n) |=> (err_rail[1] == err_rail[0]));
  // R10
  rz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rz == rz_n) |=> (err_rail[1] == err_rail[0]));
  // R11
  load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rail[1] == ld_rail[0]) |=> (err_rail[1] == err_rail[0]));
endmodule

bind seq_decode_chk seq_decode_chk_sva sva_i (.*);

// File: tb/seq_decode_chk_test.sv
module seq_decode_chk_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [2:0] op_zc = 3'd4;
  logic cc = 1'b0, cc_n = 1'b1, rz = 1'b0, rz_n = 1'b1;
  logic [1:0] ld_rail = 2'b01;
  logic ctl_reset, ctl_pcclr, ctl_ld, ctl_dec, ctl_regoe, ctl_stkoe, ctl_extoe;
  logic ctl_push, ctl_pop, ctl_push_n, ctl_pop_n, en_pl, en_map, en_vec;
  logic [2:0] chk_word;
  logic [1:0] err_rail;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seq_decode_chk uut (.*);

  function automatic logic [11:0] model(input logic [3:0] o, input logic c, input logic z);
    logic rs = 0, pc = 0, ld = 0, dc = 0, ro = 0, so = 0, ex = 0, pu = 0, po = 0;
    logic pl = 1, mp = 0, vc = 0;
    if (o == 0) begin rs = 1; pc = 1; end
    else if (o == 2) begin pl = 0; mp = 1; ex = 1; end
    else if (o == 6) begin pl = 0; vc = 1; ex = c; end
    else if (o == 12) ld = 1;
    else if (o == 1) begin ex = c; pu = c; end
    else if (o == 3 || o == 11) begin ex = c; po = (o == 11) && c; end
    else if (o == 4) begin pu = 1; ld = c; end
    else if (o == 5 || o == 7) begin pu = (o == 5); ex = c; ro = !c; end
    else if (o == 10) begin so = c; po = c; end
    else if (o == 13) begin po = c; so = !c; end
    else if (o == 8) begin if (z) po = 1; else begin so = 1; dc = 1; end end
    else if (o == 9) begin if (!z) begin ex = 1; dc = 1; end end
    else if (o == 15) begin
      if (c) po = 1; else if (!z) begin so = 1; dc = 1; end else begin ex = 1; po = 1; end
    end
    return {rs, pc, ld, dc, ro, so, ex, pu, po, pl, mp, vc};
  endfunction

  function automatic int ones(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += v[i];
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [2:0] zc, input logic c, input logic cn,
                      input logic z, input logic zn, input logic [1:0] ld, input bit want_ok,
                      input string req);
    logic [11:0] exp;
    int e_word;
    @(negedge clk);
    op = o; op_zc = zc; cc = c; cc_n = cn; rz = z; rz_n = zn; ld_rail = ld;
    #1;
    exp = model(o, c, z);
    e_word = 8 - ones({4'b0, exp}) - ones({12'b0, o});
    chk({ctl_reset, ctl_pcclr, ctl_ld, ctl_dec, ctl_regoe, ctl_stkoe, ctl_extoe,
         ctl_push, ctl_pop, en_pl, en_map, en_vec} == exp, "R1/R2/R3 controls",
        {ctl_reset, ctl_pcclr, ctl_ld, ctl_dec, ctl_regoe, ctl_stkoe, ctl_extoe,
         ctl_push, ctl_pop, en_pl, en_map, en_vec}, exp);
    chk($countones({en_pl, en_map, en_vec}) == 1, "R4 enables", {en_pl, en_map, en_vec}, 0);
    chk(ctl_push_n == !exp[4] && ctl_pop_n == !exp[3], "R5 inverted pair",
        {ctl_push_n, ctl_pop_n}, {!exp[4], !exp[3]});
    chk(chk_word == 3'(e_word) && e_word >= 0 && e_word <= 6, "R6 check word", chk_word, e_word);
    @(posedge clk);
    #1;
    chk((err_rail[1] != err_rail[0]) == want_ok, req, err_rail, want_ok);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(err_rail == 2'b10, "R12 reset pair", err_rail, 2'b10);
    @(negedge clk) rst_n = 1'b1;
    // R7 clean sweep over every opcode, condition and zero value
    for (int o = 0; o < 16; o++)
      for (int c = 0; c < 2; c++)
        for (int z = 0; z < 2; z++)
          step(4'(o), 3'(4 - ones({12'b0, 4'(o)})), c[0], !c[0], z[0], !z[0],
               (o[0] ^ c[0]) ? 2'b10 : 2'b01, 1'b1, "R7 clean pair");
    // R8 every wrong opcode check value
    for (int o = 0; o < 16; o++)
      for (int d = 1; d < 8; d++)
        step(4'(o), 3'(4 - ones({12'b0, 4'(o)}) + d), o[1], !o[1], o[2], !o[2],
             2'b01, 1'b0, "R8 bad opcode check");
    for (int o = 0; o < 16; o += 3) begin
      for (int c = 0; c < 2; c++) begin
        // R9
        step(4'(o), 3'(4 - ones({12'b0, 4'(o)})), c[0], c[0], 1'b0, 1'b1, 2'b10, 1'b0,
             "R9 condition complement");
        // R10
        step(4'(o), 3'(4 - ones({12'b0, 4'(o)})), 1'b1, 1'b0, c[0], c[0], 2'b01, 1'b0,
             "R10 zero complement");
        // R11
        step(4'(o), 3'(4 - ones({12'b0, 4'(o)})), 1'b0, 1'b1, 1'b1, 1'b0,
             c[0] ? 2'b11 : 2'b00, 1'b0, "R11 load pair");
      end
    end
    // recovery after errors: R7
    step(4'hE, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, "R7 recovery");
    // R12 reset re-entry
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk(err_rail == 2'b10, "R12 reset pair", err_rail, 2'b10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule